// File: doc/BRIEF.md
# PPS-Aligned Seconds and Ticks Timekeeper

This block keeps the time of day as a pair of counters: a sub-second tick count that advances on every clock, and a seconds count that advances each time the tick count completes one programmed second. Software reaches it through a small write-only configuration port. It stages a seconds value first. It then commits a load by writing the tick value. The staged pair is applied either on that same clock edge or, when deferred, on the next chosen edge of a pulse-per-second input.

Two pulse-per-second inputs are offered: one from an external connector and one from a cable link to a neighbouring unit. Each passes through its own two-flop synchronizer. A configuration flag picks which one is used, and another flag picks whether its rising or its falling edge counts. A deferred load stays armed for as long as it takes, and it is used by exactly one edge. A snapshot strobe copies seconds and ticks from the same cycle into a pair of readback outputs. Software can therefore read the two halves without ever seeing a torn value across a rollover.

Top module: `pps_timekeeper`

## Requirements
- R1: While reset is high, the live time and the snapshot read 0 seconds and 0 ticks. Reset also clears the flags and the immediate bit, and sets the ticks-per-second count to the parameter TPS_DEFAULT.
- R2: Outside of a load, the tick count rises by one on every clock. When ticks+1 reaches the ticks-per-second count, ticks return to 0 and seconds rise by one in the same cycle.
- R3: A write to address 0 only stages the seconds value. The live time is unaffected until a commit applies it.
- R4: A write to address 1 commits a load of {staged seconds, written ticks}. When bit 0 of the immediate register at address 3 is 1, the load takes effect on that write's clock edge.
- R5: When the immediate bit is 0, a commit arms the load. The load stays armed indefinitely and is applied on the third clock edge after the selected PPS input changes to form the selected edge.
- R6: Bit 0 of the flags register at address 2 picks the active PPS edge: 0 means falling and 1 means rising. The opposite edge does not apply an armed load.
- R7: Bit 1 of the flags register picks the PPS source: 0 means the external input and 1 means the link input. Edges on the unselected input do not apply an armed load.
- R8: An armed load is applied by exactly one edge. Later edges do not reload the time.
- R9: An immediate commit made while a deferred load is armed loads at once and disarms the earlier load, so a following PPS edge changes nothing.
- R10: When snap_req is high at a clock edge, snap_secs and snap_ticks take the live seconds and ticks of that same cycle. Otherwise they hold.
- R11: A write to address 4 sets the ticks-per-second count used by the rollover in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pps_ext | input | 1 | Pulse-per-second from the external connector (asynchronous) |
| pps_link | input | 1 | Pulse-per-second from the cable link (asynchronous) |
| snap_req | input | 1 | Capture live time into the snapshot outputs |
| now_secs | output | 32 | Live seconds count |
| now_ticks | output | 32 | Live tick count |
| snap_secs | output | 32 | Captured seconds |
| snap_ticks | output | 32 | Captured ticks |

## Verification
The counters are first loaded immediately with a small ticks-per-second value. Snapshots are then taken just before, exactly at and well past a rollover, which separates a wrong wrap point from a torn seconds/ticks pair. Deferred loads are tried with each edge polarity and each source. Each of these cases also drives the non-matching edge or the unselected input first, which tells a correct selection from a block that reacts to any transition. Repeated edges after a load, and an immediate commit over an armed load, tell single-use arming apart from a load that re-fires or outlives its cancellation.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int SEC_W  = 32;
    localparam int TICK_W = 32;
    localparam int CFG_DW = 32;
    localparam int CFG_AW = 3;
    localparam int NSRC   = 2;

    typedef struct packed {
        logic [SEC_W-1:0]  secs;
        logic [TICK_W-1:0] ticks;
    } tk_time_t;

    typedef struct packed {
        logic src_link;   // bit 1: 0 external, 1 link
        logic rise;       // bit 0: 0 falling, 1 rising
    } tk_flags_t;

    typedef enum logic [CFG_AW-1:0] {
        TK_REG_SECS  = 3'd0,
        TK_REG_TICKS = 3'd1,
        TK_REG_FLAGS = 3'd2,
        TK_REG_IMM   = 3'd3,
        TK_REG_TPS   = 3'd4
    } tk_reg_e;

    // One clock of free-running advance with rollover at tps.
    function automatic tk_time_t tk_step(tk_time_t cur, logic [TICK_W-1:0] tps);
        tk_time_t r;
        logic [TICK_W:0] inc;
        r   = cur;
        inc = {1'b0, cur.ticks} + {{TICK_W{1'b0}}, 1'b1};
        if (inc >= {1'b0, tps}) begin
            r.ticks = '0;
            r.secs  = cur.secs + {{(SEC_W-1){1'b0}}, 1'b1};
        end else begin
            r.ticks = inc[TICK_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/tk_cfg_regs.sv
module tk_cfg_regs
    import tk_pkg::*;
#(
    parameter logic [TICK_W-1:0] TPS_DEFAULT = 32'd100_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_AW-1:0]    addr,
    input  logic [CFG_DW-1:0]    wdata,
    output tk_flags_t            flags,
    output logic                 imm,
    output logic [TICK_W-1:0]    tps,
    output logic                 commit,
    output tk_time_t             commit_val
);

    logic [SEC_W-1:0] stage_secs_q;
    tk_flags_t        flags_q;
    logic             imm_q;
    logic [TICK_W-1:0] tps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_secs_q <= '0;
            flags_q      <= '0;
            imm_q        <= 1'b0;
            tps_q        <= TPS_DEFAULT;
        end else if (we) begin
            case (tk_reg_e'(addr))
                TK_REG_SECS:  stage_secs_q <= wdata[SEC_W-1:0];
                TK_REG_FLAGS: flags_q      <= tk_flags_t'(wdata[1:0]);
                TK_REG_IMM:   imm_q        <= wdata[0];
                TK_REG_TPS:   tps_q        <= wdata[TICK_W-1:0];
                default: ;
            endcase
        end
    end

    // The ticks write is the commit; its data goes straight into the load value.
    assign commit           = we && (tk_reg_e'(addr) == TK_REG_TICKS);
    assign commit_val.secs  = stage_secs_q;
    assign commit_val.ticks = wdata[TICK_W-1:0];
    assign flags            = flags_q;
    assign imm              = imm_q;
    assign tps              = tps_q;

endmodule

// File: rtl/tk_pps_edge.sv
module tk_pps_edge
    import tk_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pps_in,
    input  tk_flags_t       flags,
    output logic            pps_edge
);

    localparam int TOP = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] sync_q [NSRC];
    logic                  sel;
    logic                  prev_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= '0;
            else     sync_q[g] <= {sync_q[g][SYNC_DEPTH-2:0], pps_in[g]};
        end
    end

    assign sel = sync_q[flags.src_link][TOP];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sel;
    end

    assign pps_edge = flags.rise ? (sel & ~prev_q) : (~sel & prev_q);

endmodule

// File: rtl/tk_time_core.sv
module tk_time_core
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  tk_time_t          commit_val,
    input  logic              imm,
    input  logic [TICK_W-1:0] tps,
    input  logic              pps_edge,
    input  logic              snap_req,
    output tk_time_t          now,
    output tk_time_t          snap,
    output logic              pend
);

    tk_time_t cur_q, nxt, pend_val_q, snap_q;
    logic     pend_q;

    always_comb begin
        if (commit && imm)          nxt = commit_val;
        else if (pend_q && pps_edge) nxt = pend_val_q;
        else                         nxt = tk_step(cur_q, tps);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            pend_q     <= 1'b0;
            pend_val_q <= '0;
            snap_q     <= '0;
        end else begin
            cur_q <= nxt;
            if (commit) begin
                pend_q     <= ~imm;
                pend_val_q <= commit_val;
            end else if (pps_edge) begin
                pend_q <= 1'b0;
            end
            if (snap_req) snap_q <= cur_q;
        end
    end

    assign now  = cur_q;
    assign snap = snap_q;
    assign pend = pend_q;

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter logic [TICK_W-1:0] TPS_DEFAULT = 32'd100_000_000,
    parameter int                SYNC_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              pps_ext,
    input  logic              pps_link,
    input  logic              snap_req,
    output logic [SEC_W-1:0]  now_secs,
    output logic [TICK_W-1:0] now_ticks,
    output logic [SEC_W-1:0]  snap_secs,
    output logic [TICK_W-1:0] snap_ticks
);

    tk_flags_t         flags;
    logic              imm;
    logic [TICK_W-1:0] tps;
    logic              commit;
    tk_time_t          commit_val;
    logic              pps_edge;
    logic              pend;
    tk_time_t          now_t, snap_t;

    tk_cfg_regs #(.TPS_DEFAULT(TPS_DEFAULT)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .flags      (flags),
        .imm        (imm),
        .tps        (tps),
        .commit     (commit),
        .commit_val (commit_val)
    );

    tk_pps_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_pps (
        .clk      (clk),
        .rst      (rst),
        .pps_in   ({pps_link, pps_ext}),
        .flags    (flags),
        .pps_edge (pps_edge)
    );

    tk_time_core u_core (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_val (commit_val),
        .imm        (imm),
        .tps        (tps),
        .pps_edge   (pps_edge),
        .snap_req   (snap_req),
        .now        (now_t),
        .snap       (snap_t),
        .pend       (pend)
    );

    assign now_secs   = now_t.secs;
    assign now_ticks  = now_t.ticks;
    assign snap_secs  = snap_t.secs;
    assign snap_ticks = snap_t.ticks;

endmodule

// File: rtl/tk_checker.sv
module tk_checker
    import tk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [CFG_DW-1:0] cfg_wdata,
    input logic              snap_req,
    input logic [SEC_W-1:0]  now_secs,
    input logic [TICK_W-1:0] now_ticks,
    input logic [SEC_W-1:0]  snap_secs,
    input logic [TICK_W-1:0] snap_ticks,
    input logic              commit,
    input logic              imm,
    input logic              pend,
    input logic              pps_edge
);

    assert_tick_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!(commit && imm) && !(pend && pps_edge)) |=>
            ((now_ticks == $past(now_ticks) + 1'b1) && (now_secs == $past(now_secs))) ||
            ((now_ticks == '0) && (now_secs == $past(now_secs) + 1'b1)));

    assert_stage_only_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd0 && !(pend && pps_edge)) |=>
            (now_secs == $past(now_secs)) || (now_secs == $past(now_secs) + 1'b1));

    assert_imm_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 3'd1 && imm) |=> (now_ticks == $past(cfg_wdata)));

    assert_single_use_R8: assert property (@(posedge clk) disable iff (rst)
        (pend && pps_edge && !commit) |=> !pend);

    assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && imm) |=> !pend);

    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !snap_req |=> ($stable(snap_secs) && $stable(snap_ticks)));

    assert_snap_take_R10: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> (snap_ticks == $past(now_ticks)) && (snap_secs == $past(now_secs)));

endmodule

bind pps_timekeeper tk_checker u_tk_checker (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .snap_req   (snap_req),
    .now_secs   (now_secs),
    .now_ticks  (now_ticks),
    .snap_secs  (snap_secs),
    .snap_ticks (snap_ticks),
    .commit     (commit),
    .imm        (imm),
    .pend       (pend),
    .pps_edge   (pps_edge)
);

// File: tb/pps_timekeeper_bench.sv
module pps_timekeeper_bench;

    localparam logic [31:0] TPS_DEF = 32'd1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pps_ext = 1'b0;
    logic        pps_link = 1'b0;
    logic        snap_req = 1'b0;
    logic [31:0] now_secs, now_ticks, snap_secs, snap_ticks;

    always #4 clk = ~clk;   // 125 MHz

    pps_timekeeper #(.TPS_DEFAULT(TPS_DEF)) u_pps_timekeeper (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pps_ext(pps_ext), .pps_link(pps_link),
        .snap_req(snap_req), .now_secs(now_secs), .now_ticks(now_ticks),
        .snap_secs(snap_secs), .snap_ticks(snap_ticks)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state: time (b_s, b_t) held at bench cycle b_cyc
    longint b_s = 0, b_t = 0, b_cyc = 0, tps_m = TPS_DEF;

    typedef struct {
        string       req;
        logic [31:0] s;
        logic [31:0] t;
    } exp_t;
    exp_t sb[$];
    logic [31:0] last_s, last_t;

    function automatic void model_at(input longint c, output logic [31:0] s, output logic [31:0] t);
        longint tot;
        tot = b_t + (c - b_cyc);
        s = 32'(b_s + tot / tps_m);
        t = 32'(tot % tps_m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_live(input string req);
        logic [31:0] es, et;
        model_at(cyc, es, et);
        check(req, now_secs, es);
        check(req, now_ticks, et);
    endtask

    task automatic rebase(input longint s, input longint t);
        b_s = s; b_t = t; b_cyc = cyc;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: request a snapshot and push its expected pair
    task automatic snap(input string req);
        exp_t e;
        e.req = req;
        model_at(cyc, e.s, e.t);
        sb.push_back(e);
        last_s = e.s; last_t = e.t;
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    // change a PPS input, wait three edges (two sync flops plus the load)
    task automatic pps_set(input bit link, input logic v);
        if (link) pps_link = v; else pps_ext = v;
        idle(3);
    endtask

    // monitor: pop and compare each snapshot one cycle after its request
    initial begin
        forever begin
            @(posedge clk);
            if (snap_req) begin
                exp_t e;
                @(negedge clk);
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R10 actual=unexpected snapshot expected=none");
                end else begin
                    e = sb.pop_front();
                    check(e.req, snap_secs, e.s);
                    check(e.req, snap_ticks, e.t);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        check("R1 secs", now_secs, 0);
        check("R1 ticks", now_ticks, 0);
        check("R1 snap", snap_ticks, 0);
        rst = 1'b0;
        rebase(0, 0);
        idle(7);
        chk_live("R2 free run");

        // R3: staging seconds leaves live time alone
        wr(3'd0, 32'd10);
        chk_live("R3 stage only");

        // R11/R4: small rollover and immediate load
        wr(3'd4, 32'd5);
        wr(3'd3, 32'd1);
        wr(3'd1, 32'd2);
        rebase(10, 2); tps_m = 5;
        chk_live("R4 immediate load");
        idle(2);
        snap("R10 before wrap");
        snap("R10 at wrap R2");
        idle(11);
        snap("R11 several seconds");
        idle(4);
        check("R10 hold secs", snap_secs, last_s);
        check("R10 hold ticks", snap_ticks, last_t);

        wr(3'd4, 32'd7);
        wr(3'd1, 32'd6);
        wr(3'd0, 32'd0);   // stage seconds 0 for next load
        wr(3'd1, 32'd6);
        rebase(0, 6); tps_m = 7;
        idle(1);
        chk_live("R11 new rollover");

        // R5/R6: deferred load on falling external edge
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd1);
        idle(20);
        chk_live("R5 armed no load");
        pps_set(1'b0, 1'b1);
        chk_live("R6 rising ignored");
        pps_set(1'b0, 1'b0);
        rebase(100, 1);
        chk_live("R5 load on edge");
        pps_set(1'b0, 1'b1);
        pps_set(1'b0, 1'b0);
        chk_live("R8 no second load");

        // R6: rising polarity
        wr(3'd2, 32'd1);
        wr(3'd0, 32'd200);
        wr(3'd1, 32'd3);
        pps_set(1'b0, 1'b1);
        rebase(200, 3);
        chk_live("R6 rising load");

        // R7: link source
        wr(3'd2, 32'd3);
        wr(3'd0, 32'd300);
        wr(3'd1, 32'd4);
        pps_set(1'b0, 1'b0);
        pps_set(1'b0, 1'b1);
        chk_live("R7 external ignored");
        pps_set(1'b1, 1'b1);
        rebase(300, 4);
        chk_live("R7 link load");
        snap("R10 after link load");

        // R9: immediate commit cancels armed load
        wr(3'd2, 32'd1);
        wr(3'd3, 32'd0);
        wr(3'd0, 32'd400);
        wr(3'd1, 32'd5);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd500);
        wr(3'd1, 32'd6);
        rebase(500, 6);
        chk_live("R9 immediate over armed");
        pps_set(1'b0, 1'b0);
        pps_set(1'b0, 1'b1);
        chk_live("R9 disarmed");

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule